// File: doc/BRIEF.md
# Zigzag Candidate Enumerator

This block lists the alternative PAM symbols for one level of a depth-first tree search. Candidates come out in order of growing distance from the nearest point, and no division is needed past the first slice. A load strobe supplies the slicer's nearest odd-integer point, the sign of its rounding correction, the active constellation size, and the level's column of the triangular channel factor together with the current partial-residual vector. Each advance strobe then produces one further candidate on the other side of the nearest point, two units further out than the previous candidate on that side. The new residual vector for that candidate is computed with one multiplier per entry, all entries at once.

When one side of the walk leaves the active constellation, the block drops that side and keeps stepping along the other. An exhausted flag rises with the last point of the constellation. The search controller uses the valid flag to decide whether a candidate can be expanded, and uses the exhausted flag to decide when to backtrack.

Top module: `zz_cand_enum`

## Requirements
- R1: While reset is held, and after it is released, cand_valid and cand_ok are 0, cand_sym and psi_out are 0, and exhausted is 1.
- R2: A load strobe makes cand_valid 1 on the next cycle. cand_sym then equals s_first, and cand_ok is 1 exactly when s_first lies inside the active constellation.
- R3: qam_sel picks the active PAM range: 2'b00 gives ±1, 2'b01 gives ±3, and 2'b10 or 2'b11 give ±7. A candidate with cand_ok high always lies inside this range, using the size latched at the last load.
- R4: Consecutive candidates alternate sides of s_first, and each pair moves two units further out. When corr_neg is 1 the second candidate is s_first+2; when it is 0 the second candidate is s_first-2.
- R5: Once a side runs past the range limit, every later candidate comes from the other side, in steps of two, until that side also runs out.
- R6: exhausted is 1 in the same cycle as the last in-range candidate. For an in-range s_first this is the Q-th output, where Q = limit+1. A loaded s_first outside the range gives exhausted 1 at once.
- R7: An advance while exhausted gives cand_valid 1 and cand_ok 0, and leaves cand_sym and psi_out unchanged.
- R8: Every produced candidate carries psi_out entry i = psi_base[i] − r_base[i]·cand_sym. psi_base and r_base are the psi_in and r_col values latched at the last load.
- R9: A load has priority over a simultaneous advance and restarts the walk from the new s_first.
- R10: A cycle with no strobe gives cand_valid 0 on the next cycle and leaves cand_sym and psi_out unchanged.
- R11: An advance before any load gives cand_ok 0 with exhausted 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a new walk from s_first |
| adv | input | 1 | Request the next candidate |
| s_first | input | SYM_W (4) | Nearest PAM point, signed odd integer |
| corr_neg | input | 1 | 1 when the rounding correction is negative (second candidate goes upward) |
| qam_sel | input | 2 | Constellation size: 00 = 4-QAM, 01 = 16-QAM, 10/11 = 64-QAM |
| r_col | input | N*RW | Column of the triangular factor for this level, signed entries |
| psi_in | input | N*DW | Partial-residual vector from the level above, signed entries |
| cand_sym | output | SYM_W (4) | Current candidate symbol, signed |
| cand_ok | output | 1 | Candidate lies inside the active constellation |
| cand_valid | output | 1 | Pulse one cycle after a load or advance |
| exhausted | output | 1 | No in-range candidate remains |
| psi_out | output | N*OW | Updated residual vector for cand_sym, signed entries |

## Verification
The bench builds the block with four residual lanes, 10-bit residual entries and 8-bit factor entries. With these values every odd starting symbol from −7 to 7 can be walked to exhaustion under each size code, including the reserved one, and in both correction directions. That sweep covers starts at the range edges, starts outside a smaller constellation, and walks where one side runs out early. The small lane count keeps the per-lane products checkable by plain integer arithmetic at every step. Separate sequences cover an advance before any load, a reload in the middle of a walk with a coincident advance, and idle cycles.

// File: rtl/zz_pkg.sv
`timescale 1ns/1ps
package zz_pkg;
    localparam int SYM_W = 4;
    localparam int SW    = SYM_W + 2;
    localparam int STEP  = 2;

    typedef logic signed [SW-1:0] sym_t;

    typedef enum logic [1:0] {
        QAM4  = 2'b00,
        QAM16 = 2'b01,
        QAM64 = 2'b10,
        QAMX  = 2'b11
    } qam_e;

    typedef struct packed {
        logic armed;
        logic pref_up;
        sym_t up;
        sym_t dn;
    } walk_t;

    function automatic sym_t pam_top(input qam_e q);
        case (q)
            QAM4:    return sym_t'(1);
            QAM16:   return sym_t'(3);
            default: return sym_t'(7);
        endcase
    endfunction

    function automatic logic fits(input sym_t v, input sym_t lim);
        return (v <= lim) && (v >= -lim);
    endfunction
endpackage

// File: rtl/zz_psi_lane.sv
`timescale 1ns/1ps
module zz_psi_lane #(
    parameter int DW = 14,
    parameter int RW = 14,
    parameter int SYMW = 4,
    parameter int OW = 19
) (
    input  logic [DW-1:0]   psi_i,
    input  logic [RW-1:0]   rcol_i,
    input  logic [SYMW-1:0] sym_i,
    output logic [OW-1:0]   psi_o
);
    logic signed [OW-1:0] pe, re, se, prod;

    assign pe   = {{(OW-DW){psi_i[DW-1]}}, psi_i};
    assign re   = {{(OW-RW){rcol_i[RW-1]}}, rcol_i};
    assign se   = {{(OW-SYMW){sym_i[SYMW-1]}}, sym_i};
    assign prod = re * se;
    assign psi_o = pe - prod;
endmodule

// File: rtl/zz_step_ctrl.sv
`timescale 1ns/1ps
module zz_step_ctrl
    import zz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic [SYM_W-1:0] s_first,
    input  logic             corr_neg,
    input  qam_e             qam,
    output logic [SYM_W-1:0] pick_sym,
    output logic             pick_ok,
    output logic             pick_take,
    output logic             exh_next,
    output sym_t             act_lim
);
    walk_t st_q, st_d;
    qam_e  qam_q, qam_d;
    sym_t  s_ext, lim, lim_d;
    logic  up_ok, dn_ok, take_up, take_dn;

    assign s_ext   = {{(SW-SYM_W){s_first[SYM_W-1]}}, s_first};
    assign act_lim = pam_top(qam_q);

    always_comb begin
        st_d      = st_q;
        qam_d     = qam_q;
        pick_sym  = '0;
        pick_ok   = 1'b0;
        pick_take = 1'b0;
        lim       = pam_top(qam_q);
        up_ok     = st_q.armed && fits(st_q.up, lim);
        dn_ok     = st_q.armed && fits(st_q.dn, lim);
        take_up   = 1'b0;
        take_dn   = 1'b0;
        if (load) begin
            qam_d      = qam;
            lim        = pam_top(qam);
            pick_sym   = s_first;
            pick_ok    = fits(s_ext, lim);
            pick_take  = 1'b1;
            st_d.armed   = fits(s_ext, lim);
            st_d.pref_up = corr_neg;
            st_d.up      = s_ext + sym_t'(STEP);
            st_d.dn      = s_ext - sym_t'(STEP);
        end else if (adv) begin
            take_up = up_ok && (st_q.pref_up || !dn_ok);
            take_dn = dn_ok && !take_up;
            if (take_up) begin
                pick_sym     = SYM_W'(st_q.up);
                st_d.up      = st_q.up + sym_t'(STEP);
                st_d.pref_up = 1'b0;
            end else if (take_dn) begin
                pick_sym     = SYM_W'(st_q.dn);
                st_d.dn      = st_q.dn - sym_t'(STEP);
                st_d.pref_up = 1'b1;
            end
            pick_ok   = take_up || take_dn;
            pick_take = take_up || take_dn;
        end
        lim_d    = pam_top(qam_d);
        exh_next = !st_d.armed || !(fits(st_d.up, lim_d) || fits(st_d.dn, lim_d));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            qam_q <= QAM64;
        end else begin
            st_q  <= st_d;
            qam_q <= qam_d;
        end
    end

    // R5
    walk_order_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.armed |-> (st_q.up > st_q.dn));

    // R4
    side_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && up_ok && dn_ok) |=> (st_q.pref_up != $past(st_q.pref_up)));
endmodule

// File: rtl/zz_cand_enum.sv
`timescale 1ns/1ps
module zz_cand_enum
    import zz_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 14,
    parameter int RW = 14,
    localparam int OW = ((DW > RW + SYM_W) ? DW : (RW + SYM_W)) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic [SYM_W-1:0] s_first,
    input  logic             corr_neg,
    input  logic [1:0]       qam_sel,
    input  logic [N*RW-1:0]  r_col,
    input  logic [N*DW-1:0]  psi_in,
    output logic [SYM_W-1:0] cand_sym,
    output logic             cand_ok,
    output logic             cand_valid,
    output logic             exhausted,
    output logic [N*OW-1:0]  psi_out
);
    logic [N*DW-1:0]  psi_hold;
    logic [N*RW-1:0]  r_hold;
    logic [N*OW-1:0]  lane_o;
    logic [SYM_W-1:0] pick_sym;
    logic             pick_ok, pick_take, exh_next;
    sym_t             act_lim, sym_ext;

    zz_step_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .adv      (adv),
        .s_first  (s_first),
        .corr_neg (corr_neg),
        .qam      (qam_e'(qam_sel)),
        .pick_sym (pick_sym),
        .pick_ok  (pick_ok),
        .pick_take(pick_take),
        .exh_next (exh_next),
        .act_lim  (act_lim)
    );

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [DW-1:0] p_sel;
        logic [RW-1:0] r_sel;
        assign p_sel = load ? psi_in[g*DW +: DW] : psi_hold[g*DW +: DW];
        assign r_sel = load ? r_col[g*RW +: RW]  : r_hold[g*RW +: RW];
        zz_psi_lane #(.DW(DW), .RW(RW), .SYMW(SYM_W), .OW(OW)) u_lane (
            .psi_i (p_sel),
            .rcol_i(r_sel),
            .sym_i (pick_sym),
            .psi_o (lane_o[g*OW +: OW])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psi_hold   <= '0;
            r_hold     <= '0;
            cand_sym   <= '0;
            cand_ok    <= 1'b0;
            cand_valid <= 1'b0;
            exhausted  <= 1'b1;
            psi_out    <= '0;
        end else begin
            cand_valid <= load || adv;
            if (load) begin
                psi_hold <= psi_in;
                r_hold   <= r_col;
            end
            if (load || adv) begin
                cand_ok   <= pick_ok;
                exhausted <= exh_next;
            end
            if (pick_take) begin
                cand_sym <= pick_sym;
                psi_out  <= lane_o;
            end
        end
    end

    assign sym_ext = {{(SW-SYM_W){cand_sym[SYM_W-1]}}, cand_sym};

    // R2
    strobe_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (load || adv) |=> cand_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(load || adv) |=> (!cand_valid && $stable(cand_sym) && $stable(psi_out)));

    // R7
    dry_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (exhausted && adv && !load) |=> (!cand_ok && exhausted && $stable(cand_sym)));

    // R3
    ok_range_chk: assert property (@(posedge clk) disable iff (rst)
        cand_ok |-> fits(sym_ext, act_lim));
endmodule

// File: tb/sim_zz_cand_enum.sv
`timescale 1ns/1ps
module sim_zz_cand_enum;
    localparam int N  = 4;
    localparam int DW = 10;
    localparam int RW = 8;
    localparam int SY = 4;
    localparam int OW = 13;

    logic clk = 1'b0;
    logic rst, load, adv, corr_neg;
    logic [SY-1:0]   s_first;
    logic [1:0]      qam_sel;
    logic [N*RW-1:0] r_col;
    logic [N*DW-1:0] psi_in;
    logic [SY-1:0]   cand_sym;
    logic            cand_ok, cand_valid, exhausted;
    logic [N*OW-1:0] psi_out;

    int total = 0;
    int bad   = 0;
    int pv[N];
    int rv[N];
    int seq[16];
    int nseq;
    int tick = 0;

    always #2.5 clk = ~clk;

    zz_cand_enum #(.N(N), .DW(DW), .RW(RW)) u0 (
        .clk(clk), .rst(rst), .load(load), .adv(adv), .s_first(s_first),
        .corr_neg(corr_neg), .qam_sel(qam_sel), .r_col(r_col), .psi_in(psi_in),
        .cand_sym(cand_sym), .cand_ok(cand_ok), .cand_valid(cand_valid),
        .exhausted(exhausted), .psi_out(psi_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_psi(input string req, input int sym);
        for (int i = 0; i < N; i++)
            check(req, int'($signed(psi_out[i*OW +: OW])), pv[i] - rv[i] * sym);
    endtask

    task automatic check_out(input string req, input int sym, input int ok, input int ex);
        check({req, " valid"}, int'(cand_valid), 1);
        check({req, " sym"}, int'($signed(cand_sym)), sym);
        check({req, " ok"}, int'(cand_ok), ok);
        check({req, " exhausted"}, int'(exhausted), ex);
        check_psi({req, " psi R8"}, sym);
    endtask

    function automatic int lim_of(input int q);
        return (q == 0) ? 1 : (q == 1) ? 3 : 7;
    endfunction

    task automatic set_vec(input int t);
        for (int i = 0; i < N; i++) begin
            pv[i] = ((t * 37 + i * 53) % 900) - 450;
            rv[i] = ((t * 29 + i * 71) % 250) - 125;
            psi_in[i*DW +: DW] = DW'(pv[i]);
            r_col[i*RW +: RW]  = RW'(rv[i]);
        end
    endtask

    task automatic do_load(input int s, input int c, input int q, input logic with_adv);
        tick++;
        set_vec(tick);
        s_first  = SY'(s);
        corr_neg = c[0];
        qam_sel  = q[1:0];
        load = 1'b1;
        adv  = with_adv;
        @(negedge clk);
        load = 1'b0;
        adv  = 1'b0;
    endtask

    task automatic do_adv();
        adv = 1'b1;
        @(negedge clk);
        adv = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R6 actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; load = 1'b0; adv = 1'b0; corr_neg = 1'b0;
        s_first = '0; qam_sel = '0; r_col = '0; psi_in = '0;
        for (int i = 0; i < N; i++) begin pv[i] = 0; rv[i] = 0; end
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 valid", int'(cand_valid), 0);
        check("R1 ok", int'(cand_ok), 0);
        check("R1 exhausted", int'(exhausted), 1);
        check("R1 sym", int'($signed(cand_sym)), 0);
        check_psi("R1 psi", 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after release", int'(cand_valid), 0);
        // R11 advance before any load
        do_adv();
        check("R11 valid", int'(cand_valid), 1);
        check("R11 ok", int'(cand_ok), 0);
        check("R11 exhausted", int'(exhausted), 1);
        check("R11 sym", int'($signed(cand_sym)), 0);

        // R2 R3 R4 R5 R6 R7 R8 R9: full sweep
        for (int q = 0; q < 4; q++) begin
            for (int c = 0; c < 2; c++) begin
                for (int s = -7; s <= 7; s += 2) begin
                    int lim, e, a, b, last;
                    logic inr;
                    lim = lim_of(q);
                    e = (c == 1) ? 1 : -1;
                    inr = (s <= lim) && (s >= -lim);
                    nseq = 0;
                    if (inr) begin
                        seq[0] = s;
                        nseq = 1;
                        for (int j = 1; j <= 7; j++) begin
                            a = s + e * 2 * j;
                            b = s - e * 2 * j;
                            if (a <= lim && a >= -lim) begin seq[nseq] = a; nseq++; end
                            if (b <= lim && b >= -lim) begin seq[nseq] = b; nseq++; end
                        end
                        check("R6 count equals Q", nseq, lim + 1);
                    end
                    // R9: load together with advance in one configuration
                    do_load(s, c, q, (q == 3 && c == 1));
                    check_out("R2 load", s, int'(inr), int'(!inr || nseq <= 1));
                    for (int k = 1; k < nseq; k++) begin
                        do_adv();
                        check_out("R4 R5 step", seq[k], 1, int'(k == nseq - 1));
                    end
                    last = inr ? seq[nseq - 1] : s;
                    do_adv();
                    check_out("R7 dry advance", last, 0, 1);
                    @(negedge clk);
                    check("R10 idle valid", int'(cand_valid), 0);
                    check("R10 idle sym", int'($signed(cand_sym)), last);
                    check_psi("R10 idle psi", last);
                end
            end
        end

        // R9 reload mid-walk with coincident advance
        do_load(1, 0, 2, 1'b0);
        check_out("R4 first", 1, 1, 0);
        do_adv();
        check_out("R4 down first", -1, 1, 0);
        do_load(-3, 1, 1, 1'b1);
        check_out("R9 reload", -3, 1, 0);
        do_adv();
        check_out("R9 restart up", -1, 1, 0);
        do_adv();
        check_out("R9 continue up", 1, 1, 0);
        do_adv();
        check_out("R9 last", 3, 1, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule